// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits behind the write port of a parallel NOR flash model or controller and turns a stream of bus write cycles into operation requests. Every accepted write carries a 16-bit word address and a 16-bit data word. The decoder follows the multi-cycle unlock patterns that guard every array-altering operation. When a pattern completes, it raises a single-cycle request for word program, sector erase, chip erase, identification-mode entry or identification-mode exit. At the same time it latches the target address and data of the final write.

The decoder also holds an identification-mode flag. While that flag is set, a small read-side lookup returns the manufacturer and device codes. The `busy` input comes from the engine that carries out programs and erases. While `busy` is high, writes are not decoded at all. A write that breaks a sequence sends the decoder back to its read/idle state.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the sequence state is idle, `id_mode` is 0, every request output is 0, and `tgt_addr` and `tgt_data` are 0.
- R2: Word program takes four writes: (5555h, AAh), (2AAAh, 55h), (5555h, A0h), then any (address, data). On the clock edge that accepts the fourth write, `prog_req` goes high, and `tgt_addr`/`tgt_data` take that write's address and data.
- R3: Sector erase takes six writes: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), then a final write of data 30h to any address. That final write raises `sect_erase_req` and latches its full address into `tgt_addr`, so `tgt_addr[15:11]` gives the 2K-word sector.
- R4: Chip erase uses the same first five writes as R3. Its final write is (5555h, 10h), and it raises `chip_erase_req`.
- R5: The writes (5555h, AAh), (2AAAh, 55h), (5555h, 90h) raise `id_enter_req` and set `id_mode` on the same edge.
- R6: Identification exit has two forms: the three-write form ending in (5555h, F0h), or a single write of data F0h to any address while the decoder is idle. Either form raises `id_exit_req` and clears `id_mode` on the same edge.
- R7: Command cycles compare only address bits 14..0 and data bits 7..0. Address bit 15 and data bits 15..8 have no effect on decoding.
- R8: A write that does not match the next expected cycle returns the decoder to idle and raises no request. That write is not re-examined as the start of a new sequence.
- R9: While `busy` is 1, a write raises no request. It also leaves both the sequence state and `id_mode` unchanged, so a sequence that was interrupted by busy writes resumes once `busy` falls.
- R10: Each request lasts exactly one cycle, and at most one request is high in any cycle.
- R11: `id_rd_data` is 00BFh when `id_mode`=1 and `rd_addr`=0. It is 2788h when `id_mode`=1 and `rd_addr`=1. It is 0000h in every other case.
- R12: An idle write that is neither (5555h, AAh) nor data F0h leaves the decoder idle and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A bus write cycle is present this clock |
| wr_addr | input | 16 | Word address of the write |
| wr_data | input | 16 | Data word of the write |
| busy | input | 1 | An internal program or erase is running |
| rd_addr | input | 16 | Read word address for the identification lookup |
| prog_req | output | 1 | Word program request pulse |
| sect_erase_req | output | 1 | Sector erase request pulse |
| chip_erase_req | output | 1 | Chip erase request pulse |
| id_enter_req | output | 1 | Identification entry pulse |
| id_exit_req | output | 1 | Identification exit pulse |
| tgt_addr | output | 16 | Address latched from the final write of a program or erase |
| tgt_data | output | 16 | Data latched from the final write of a program or erase |
| id_mode | output | 1 | Identification mode active |
| id_rd_data | output | 16 | Identification code for `rd_addr` |

## Verification
Some properties are checked on every cycle: requests are mutually exclusive, program and erase pulses last one cycle, a busy write changes neither the sequence state nor `id_mode` and raises nothing, `id_mode` changes only together with the matching entry or exit pulse, and identification data stays zero outside identification mode. Other behaviour can only be shown by the bench's scenarios. That covers whether a particular multi-write pattern is recognised, and whether an abort anywhere in a sequence suppresses the request. It also covers whether the don't-care address and data bits are really ignored, whether each sector address reaches `tgt_addr`, and whether a sequence interrupted by busy writes later resumes. The bench sweeps all sectors and every abort position to show these.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int CMP_W  = 15;
  localparam int CODE_W = 8;

  localparam logic [CMP_W-1:0]  UNLOCK_ADDR_A = 15'h5555;
  localparam logic [CMP_W-1:0]  UNLOCK_ADDR_B = 15'h2AAA;
  localparam logic [CODE_W-1:0] KEY_1      = 8'hAA;
  localparam logic [CODE_W-1:0] KEY_2      = 8'h55;
  localparam logic [CODE_W-1:0] OP_PROGRAM = 8'hA0;
  localparam logic [CODE_W-1:0] OP_ERASE   = 8'h80;
  localparam logic [CODE_W-1:0] OP_ID_IN   = 8'h90;
  localparam logic [CODE_W-1:0] OP_ID_OUT  = 8'hF0;
  localparam logic [CODE_W-1:0] OP_CHIP    = 8'h10;
  localparam logic [CODE_W-1:0] OP_SECTOR  = 8'h30;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PROG, S_ERS3, S_ERS4, S_ERS5
  } seq_state_t;

  typedef struct packed {
    logic prog;
    logic sect;
    logic chip;
    logic id_enter;
    logic id_exit;
  } cmd_ev_t;

  // True when a write's compared slices equal one expected command cycle.
  function automatic logic cycle_hit(input logic [CMP_W-1:0] a, input logic [CODE_W-1:0] d,
                                     input logic [CMP_W-1:0] ea, input logic [CODE_W-1:0] ed);
    return (a == ea) && (d == ed);
  endfunction
endpackage

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
  import fcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [CMP_W-1:0]  cmp_addr,
  input  logic [CODE_W-1:0] cmp_code,
  input  logic              busy,
  output seq_state_t        state_q,
  output cmd_ev_t           ev
);
  seq_state_t nxt;
  logic       accept;

  assign accept = wr_valid && !busy;

  always_comb begin
    nxt = state_q;
    ev  = '0;
    if (accept) begin
      nxt = S_IDLE;
      unique case (state_q)
        S_IDLE: begin
          if (cycle_hit(cmp_addr, cmp_code, UNLOCK_ADDR_A, KEY_1)) nxt = S_UNL1;
          else if (cmp_code == OP_ID_OUT) ev.id_exit = 1'b1;
        end
        S_UNL1: if (cycle_hit(cmp_addr, cmp_code, UNLOCK_ADDR_B, KEY_2)) nxt = S_UNL2;
        S_UNL2: begin
          if (cmp_addr == UNLOCK_ADDR_A) begin
            case (cmp_code)
              OP_PROGRAM: nxt = S_PROG;
              OP_ERASE:   nxt = S_ERS3;
              OP_ID_IN:   ev.id_enter = 1'b1;
              OP_ID_OUT:  ev.id_exit  = 1'b1;
              default:    ;
            endcase
          end
        end
        S_PROG: ev.prog = 1'b1;
        S_ERS3: if (cycle_hit(cmp_addr, cmp_code, UNLOCK_ADDR_A, KEY_1)) nxt = S_ERS4;
        S_ERS4: if (cycle_hit(cmp_addr, cmp_code, UNLOCK_ADDR_B, KEY_2)) nxt = S_ERS5;
        S_ERS5: begin
          if (cmp_code == OP_SECTOR) ev.sect = 1'b1;
          else if (cycle_hit(cmp_addr, cmp_code, UNLOCK_ADDR_A, OP_CHIP)) ev.chip = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= nxt;
  end
endmodule

// File: rtl/id_mode_reg.sv
module id_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic id_mode
);
  always_ff @(posedge clk) begin
    if (!rst_n)     id_mode <= 1'b0;
    else if (set_i) id_mode <= 1'b1;
    else if (clr_i) id_mode <= 1'b0;
  end
endmodule

// File: rtl/id_code_rom.sv
module id_code_rom #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 16,
  parameter logic [15:0] MFR_CODE = 16'h00BF,
  parameter logic [15:0] DEV_CODE = 16'h2788
) (
  input  logic              id_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] MFR_LOC = '0;
  localparam logic [ADDR_W-1:0] DEV_LOC = ADDR_W'(1);

  always_comb begin
    rd_data = '0;
    if (id_mode) begin
      if (rd_addr == MFR_LOC)      rd_data = DATA_W'(MFR_CODE);
      else if (rd_addr == DEV_LOC) rd_data = DATA_W'(DEV_CODE);
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              prog_req,
  output logic              sect_erase_req,
  output logic              chip_erase_req,
  output logic              id_enter_req,
  output logic              id_exit_req,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_data,
  output logic              id_mode,
  output logic [DATA_W-1:0] id_rd_data
);
  seq_state_t state_q;
  cmd_ev_t    ev;
  logic       ev_array_op;

  cmd_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .cmp_addr (wr_addr[CMP_W-1:0]),
    .cmp_code (wr_data[CODE_W-1:0]),
    .busy     (busy),
    .state_q  (state_q),
    .ev       (ev)
  );

  id_mode_reg u_idm (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (ev.id_enter),
    .clr_i   (ev.id_exit),
    .id_mode (id_mode)
  );

  id_code_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
    .id_mode (id_mode),
    .rd_addr (rd_addr),
    .rd_data (id_rd_data)
  );

  assign ev_array_op = ev.prog || ev.sect || ev.chip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_req       <= 1'b0;
      sect_erase_req <= 1'b0;
      chip_erase_req <= 1'b0;
      id_enter_req   <= 1'b0;
      id_exit_req    <= 1'b0;
      tgt_addr       <= '0;
      tgt_data       <= '0;
    end else begin
      prog_req       <= ev.prog;
      sect_erase_req <= ev.sect;
      chip_erase_req <= ev.chip;
      id_enter_req   <= ev.id_enter;
      id_exit_req    <= ev.id_exit;
      if (ev_array_op) begin
        tgt_addr <= wr_addr;
        tgt_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              busy,
  input logic [2:0]        state_bits,
  input logic              prog_req,
  input logic              sect_erase_req,
  input logic              chip_erase_req,
  input logic              id_enter_req,
  input logic              id_exit_req,
  input logic              id_mode,
  input logic [DATA_W-1:0] id_rd_data
);
  logic [4:0] reqs;
  logic       array_req;
  assign reqs      = {prog_req, sect_erase_req, chip_erase_req, id_enter_req, id_exit_req};
  assign array_req = prog_req || sect_erase_req || chip_erase_req;

  // R10
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(reqs));
  // R10
  array_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    array_req |=> !array_req);
  // R9
  busy_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (reqs == 5'b0));
  // R9
  busy_state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(state_bits) && $stable(id_mode)));
  // R2
  req_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqs != 5'b0) |-> $past(wr_valid));
  // R5
  id_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> id_enter_req);
  // R6
  id_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(id_mode) |-> id_exit_req);
  // R11
  id_data_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !id_mode |-> (id_rd_data == '0));
endmodule

bind flash_cmd_decoder flash_cmd_checker #(.DATA_W(DATA_W)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_valid       (wr_valid),
  .busy           (busy),
  .state_bits     (state_q),
  .prog_req       (prog_req),
  .sect_erase_req (sect_erase_req),
  .chip_erase_req (chip_erase_req),
  .id_enter_req   (id_enter_req),
  .id_exit_req    (id_exit_req),
  .id_mode        (id_mode),
  .id_rd_data     (id_rd_data)
);

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy = 1'b0;
  logic [15:0] rd_addr = '0;
  logic        prog_req, sect_erase_req, chip_erase_req, id_enter_req, id_exit_req;
  logic [15:0] tgt_addr, tgt_data, id_rd_data;
  logic        id_mode;

  int errors = 0;
  int checks = 0;
  logic [4:0] last_req;   // {prog, sect, chip, enter, exit}
  logic [4:0] seen;

  always #2.5 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] req_now();
    return {prog_req, sect_erase_req, chip_erase_req, id_enter_req, id_exit_req};
  endfunction

  // One write cycle; outputs sampled at the negedge after the accepting edge.
  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    last_req = req_now();
    seen |= last_req;
  endtask

  // Noise on don't-care bits (R7): address bit 15 and data high byte.
  task automatic unlock3(input logic [7:0] op, input logic [7:0] hi);
    wr({hi[0], 15'h5555}, {hi, 8'hAA});
    wr({hi[1], 15'h2AAA}, {~hi, 8'h55});
    wr({hi[2], 15'h5555}, {hi ^ 8'h3C, op});
  endtask

  task automatic erase_prefix(input logic [7:0] hi);
    unlock3(8'h80, hi);
    wr({hi[3], 15'h5555}, {hi, 8'hAA});
    wr({hi[4], 15'h2AAA}, {hi, 8'h55});
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_now() == 5'b0, "R1 reqs", req_now(), 0);
    chk(id_mode == 1'b0, "R1 id_mode", id_mode, 0);
    chk(tgt_addr == 16'h0 && tgt_data == 16'h0, "R1 tgt", tgt_addr, 0);
    rst_n = 1'b1;

    // R2 / R7 program over several targets and noise patterns
    for (int i = 0; i < 8; i++) begin
      logic [15:0] a, d;
      logic [7:0]  hi;
      a  = 16'(i * 16'h2345 + 16'h0F1);
      d  = 16'(16'hC3A5 ^ (i * 16'h1111));
      hi = 8'(i * 37 + 5);
      unlock3(8'hA0, hi);
      wr(a, d);
      chk(last_req == 5'b10000, "R2 prog_req", last_req, 5'b10000);
      chk(tgt_addr == a && tgt_data == d, "R2 target", tgt_addr, a);
      @(negedge clk);
      chk(req_now() == 5'b0, "R10 single cycle", req_now(), 0);
    end

    // R3 sector erase over every sector
    for (int s = 0; s < 32; s++) begin
      logic [15:0] sa;
      sa = {5'(s), 11'(s * 73)};
      erase_prefix(8'(s));
      wr(sa, 16'h0030);
      chk(last_req == 5'b01000, "R3 sect_erase_req", last_req, 5'b01000);
      chk(tgt_addr[15:11] == 5'(s), "R3 sector", tgt_addr[15:11], s);
    end

    // R4 chip erase
    erase_prefix(8'hE1);
    wr(16'h5555, 16'h7710);
    chk(last_req == 5'b00100, "R4 chip_erase_req", last_req, 5'b00100);

    // R5 / R11 identification entry and reads
    unlock3(8'h90, 8'h00);
    chk(last_req == 5'b00010 && id_mode, "R5 id enter", {last_req, id_mode}, 6'b000101);
    for (int r = 0; r < 4; r++) begin
      logic [15:0] ex;
      rd_addr = 16'(r);
      ex = (r == 0) ? 16'h00BF : (r == 1) ? 16'h2788 : 16'h0000;
      #1;
      chk(id_rd_data == ex, "R11 id read", id_rd_data, ex);
    end

    // R9 busy blocks the single-write exit and keeps id_mode
    busy = 1'b1;
    wr(16'h0123, 16'h00F0);
    chk(last_req == 5'b0 && id_mode, "R9 busy exit ignored", {last_req, id_mode}, 1);
    busy = 1'b0;

    // R6 single-write exit from idle
    wr(16'h4321, 16'hABF0);
    chk(last_req == 5'b00001 && !id_mode, "R6 single exit", {last_req, id_mode}, 2);
    rd_addr = 16'h0000; #1;
    chk(id_rd_data == 16'h0, "R11 outside id mode", id_rd_data, 0);

    // R6 three-write exit
    unlock3(8'h90, 8'h55);
    unlock3(8'hF0, 8'hAA);
    chk(last_req == 5'b00001 && !id_mode, "R6 sequence exit", {last_req, id_mode}, 2);

    // R8 abort at every position of an erase sequence
    for (int k = 0; k < 6; k++) begin
      logic [15:0] ca [6];
      logic [15:0] cd [6];
      ca = '{16'h5555, 16'h2AAA, 16'h5555, 16'h5555, 16'h2AAA, 16'h5555};
      cd = '{16'h00AA, 16'h0055, 16'h0080, 16'h00AA, 16'h0055, 16'h0010};
      ca[k] = 16'h1111; cd[k] = 16'h0007;
      seen = '0;
      for (int j = 0; j < 6; j++) wr(ca[j], cd[j]);
      chk(seen == 5'b0, "R8 erase abort", seen, 0);
    end

    // R8 mismatch is not re-read as a new start
    seen = '0;
    wr(16'h5555, 16'h00AA);
    wr(16'h5555, 16'h00AA);
    wr(16'h2AAA, 16'h0055);
    wr(16'h5555, 16'h00A0);
    wr(16'h0042, 16'h1234);
    chk(seen == 5'b0, "R8 no restart", seen, 0);

    // R12 idle writes matching nothing
    seen = '0;
    wr(16'h5555, 16'h00A0);
    wr(16'h2AAA, 16'h0055);
    wr(16'h0000, 16'h1234);
    chk(seen == 5'b0, "R12 idle stays idle", seen, 0);

    // R9 busy writes inside a sequence are skipped, sequence resumes
    seen = '0;
    wr(16'h5555, 16'h00AA);
    busy = 1'b1;
    wr(16'h7777, 16'h0007);
    wr(16'h5555, 16'h00F0);
    busy = 1'b0;
    chk(seen == 5'b0, "R9 busy no req", seen, 0);
    wr(16'h2AAA, 16'h0055);
    wr(16'h5555, 16'h00A0);
    wr(16'hBEEF, 16'h0F0F);
    chk(last_req == 5'b10000 && tgt_addr == 16'hBEEF, "R9 resume after busy", tgt_addr, 16'hBEEF);

    // R9 complete sequence under busy yields nothing
    busy = 1'b1; seen = '0;
    unlock3(8'hA0, 8'h00);
    wr(16'h1000, 16'h5A5A);
    busy = 1'b0;
    chk(seen == 5'b0 && tgt_addr == 16'hBEEF, "R9 busy program", seen, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule